// File: doc/BRIEF.md
# Raster Timing Generator

This block generates the line and frame timing for a parallel RGB display panel. Two counters run while the block is enabled. The pixel counter steps once per clock. The line counter steps once per line. From these counters the block drives horizontal sync, vertical sync and data-enable, and it passes a pixel-clock inversion select to the panel clock logic. During the active area it reports the pixel coordinates. It also flags pixels that lie inside one programmable layer window, and it presents a programmable background colour on active pixels outside that window.

Each timing value is held as a cumulative end position minus one. For example, the back-porch value is sync plus back porch minus one, and the total is the sum of all four spans minus one. A single write port loads these values into a shadow set. A reload request copies the shadow set into the working set, so new geometry never takes effect part-way through a write sequence. The control word and the background colour are not shadowed.

Top module: `raster_timing_gen`

## Requirements
- R1: Register writes use a single port. Addresses 0 (sync end), 1 (back-porch end), 2 (active end), 3 (total), 6 (window horizontal), 7 (window vertical) and 8 (window enable, bit 0) write only a shadow copy. Addresses 0 to 3 carry the horizontal value in bits [11:0] and the vertical value in bits [27:16]. Outputs keep following the previous working values until a reload.
- R2: Writing 1 to bit 0 of address 9 copies the whole shadow set into the working set on the next clock. The request then clears itself, so later shadow writes have no effect until another reload is issued.
- R3: The pixel counter runs from 0 to the horizontal total and then wraps to 0, and each wrap advances the line counter. The line counter wraps after the vertical total. One frame therefore lasts (total_h+1)*(total_v+1) clocks.
- R4: Horizontal sync is active while the pixel count is at or below the horizontal sync end. Vertical sync is active while the line count is at or below the vertical sync end.
- R5: Data-enable is active only when the pixel count and the line count both lie strictly above their back-porch end and at or below their active end.
- R6: Address 4 holds the control bits. Bit 1 sets the hsync polarity, bit 2 the vsync polarity and bit 3 the data-enable polarity; a 1 makes the output active-high and a 0 makes it active-low. Bit 4 drives `pclk_inv` directly.
- R7: Bit 0 of address 4 enables the block. While it is 0, both counters are held at 0, hsync, vsync and data-enable sit at their inactive levels, and the coordinates, `layer_hit` and `px_color` are 0. The first enabled clock shows position (0,0).
- R8: During data-enable, `act_x` equals the pixel count minus the horizontal back-porch end minus one, and `act_y` is formed the same way from the line count. Outside data-enable both are 0.
- R9: Address 6 holds the horizontal window start in bits [11:0] and the stop in bits [27:16], both inclusive and in pixel-counter positions. Address 7 holds the vertical start and stop in the same layout. `layer_hit` is 1 when the window is enabled, data-enable is active and both counters lie inside the window.
- R10: `px_color` carries the background colour from address 5 on active pixels outside the window, and 0 everywhere else. A write to address 5 takes effect on the next clock without a reload.
- R11: A synchronous active-high reset clears every register. After reset, hsync, vsync and data-enable are 1, and `pclk_inv`, the coordinates, `layer_hit` and `px_color` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity programmable |
| vsync | output | 1 | Vertical sync, polarity programmable |
| de | output | 1 | Data-enable, polarity programmable |
| pclk_inv | output | 1 | Pixel clock inversion select |
| act_x | output | 12 | Active-area column |
| act_y | output | 12 | Active-area row |
| layer_hit | output | 1 | Pixel lies inside the enabled layer window |
| px_color | output | 32 | Background colour outside the window, else 0 |

## Verification
The reload self-clear property assumes that the write port does not issue a second reload request on the clock directly after the first. The stimulus separates every register write by at least one idle clock. The stimulus also reloads only while the enable bit is clear, so the counters never start from a position beyond a newly loaded total. Under that condition, each line and frame length seen at the outputs comes from a single geometry. Every cumulative value written is ordered sync end < back-porch end < active end < total on both axes, which is the ordering that the sync, data-enable and coordinate rules rely on.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int VOFF   = 16;

    typedef logic [CNT_W-1:0] pos_t;

    typedef struct packed {
        pos_t h;
        pos_t v;
    } xy_t;

    typedef struct packed {
        xy_t  sync_end;
        xy_t  bp_end;
        xy_t  act_end;
        xy_t  tot_end;
        xy_t  win_lo;
        xy_t  win_hi;
        logic win_en;
    } timing_t;

    typedef struct packed {
        logic pc_pol;
        logic de_pol;
        logic vs_pol;
        logic hs_pol;
        logic en;
    } ctrl_t;

    typedef enum logic [ADDR_W-1:0] {
        A_SYNC   = 4'd0,
        A_BP     = 4'd1,
        A_ACT    = 4'd2,
        A_TOT    = 4'd3,
        A_CTRL   = 4'd4,
        A_BG     = 4'd5,
        A_WINH   = 4'd6,
        A_WINV   = 4'd7,
        A_WINEN  = 4'd8,
        A_RELOAD = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic              hs;
        logic              vs;
        logic              de;
        logic              pc;
        pos_t              x;
        pos_t              y;
        logic              hit;
        logic [DATA_W-1:0] color;
    } pix_out_t;

    function automatic pos_t lo_field(input logic [DATA_W-1:0] w);
        return w[CNT_W-1:0];
    endfunction

    function automatic pos_t hi_field(input logic [DATA_W-1:0] w);
        return w[VOFF+CNT_W-1:VOFF];
    endfunction

    function automatic xy_t unpack_xy(input logic [DATA_W-1:0] w);
        xy_t r;
        r.h = lo_field(w);
        r.v = hi_field(w);
        return r;
    endfunction

    // pol = 1 means active-high
    function automatic logic pin_level(input logic active, input logic pol);
        return active ? pol : ~pol;
    endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output timing_t           work,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] bg
);

    timing_t shadow;
    logic    reload_pend;
    logic    reload_wr;

    assign reload_wr = we && (addr == A_RELOAD) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow      <= '0;
            work        <= '0;
            ctrl        <= '0;
            bg          <= '0;
            reload_pend <= 1'b0;
        end else begin
            reload_pend <= reload_wr;
            if (reload_pend) begin
                work <= shadow;
            end
            if (we) begin
                case (addr)
                    A_SYNC:  shadow.sync_end <= unpack_xy(wdata);
                    A_BP:    shadow.bp_end   <= unpack_xy(wdata);
                    A_ACT:   shadow.act_end  <= unpack_xy(wdata);
                    A_TOT:   shadow.tot_end  <= unpack_xy(wdata);
                    A_WINH: begin
                        shadow.win_lo.h <= lo_field(wdata);
                        shadow.win_hi.h <= hi_field(wdata);
                    end
                    A_WINV: begin
                        shadow.win_lo.v <= lo_field(wdata);
                        shadow.win_hi.v <= hi_field(wdata);
                    end
                    A_WINEN: shadow.win_en <= wdata[0];
                    A_CTRL:  ctrl          <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
                    A_BG:    bg            <= wdata;
                    default: ;
                endcase
            end
        end
    end

    AST_RELOAD_SELFCLR: assert property (@(posedge clk) disable iff (rst)
        (reload_pend && !reload_wr) |=> !reload_pend); // R2

    AST_WORK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reload_pend |=> $stable(work)); // R1

endmodule

// File: rtl/raster_counters.sv
module raster_counters
    import raster_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  xy_t  tot,
    output xy_t  pos
);

    logic h_wrap;
    logic v_wrap;

    assign h_wrap = (pos.h >= tot.h);
    assign v_wrap = (pos.v >= tot.v);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pos <= '0;
        end else if (h_wrap) begin
            pos.h <= '0;
            pos.v <= v_wrap ? '0 : pos.v + pos_t'(1);
        end else begin
            pos.h <= pos.h + pos_t'(1);
        end
    end

    AST_HCNT_STEP: assert property (@(posedge clk) disable iff (rst)
        en |=> (pos.h == '0 || pos.h == pos_t'($past(pos.h) + pos_t'(1)))); // R3

    AST_VCNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && pos.h < tot.h) |=> $stable(pos.v)); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pos.h == '0 && pos.v == '0)); // R7

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
(
    input  xy_t               pos,
    input  ctrl_t             ctrl,
    input  xy_t               sync_end,
    input  xy_t               bp_end,
    input  xy_t               act_end,
    input  xy_t               win_lo,
    input  xy_t               win_hi,
    input  logic              win_en,
    input  logic [DATA_W-1:0] bg,
    output pix_out_t          pix
);

    logic hs_act, vs_act, de_act;
    logic h_in, v_in, wh_in, wv_in;

    always_comb begin
        hs_act = ctrl.en && (pos.h <= sync_end.h);
        vs_act = ctrl.en && (pos.v <= sync_end.v);
        h_in   = (pos.h > bp_end.h) && (pos.h <= act_end.h);
        v_in   = (pos.v > bp_end.v) && (pos.v <= act_end.v);
        de_act = ctrl.en && h_in && v_in;
        wh_in  = (pos.h >= win_lo.h) && (pos.h <= win_hi.h);
        wv_in  = (pos.v >= win_lo.v) && (pos.v <= win_hi.v);

        pix.hs    = pin_level(hs_act, ctrl.hs_pol);
        pix.vs    = pin_level(vs_act, ctrl.vs_pol);
        pix.de    = pin_level(de_act, ctrl.de_pol);
        pix.pc    = ctrl.pc_pol;
        pix.x     = de_act ? pos.h - bp_end.h - pos_t'(1) : '0;
        pix.y     = de_act ? pos.v - bp_end.v - pos_t'(1) : '0;
        pix.hit   = de_act && win_en && wh_in && wv_in;
        pix.color = (de_act && !pix.hit) ? bg : '0;
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pclk_inv,
    output logic [CNT_W-1:0]  act_x,
    output logic [CNT_W-1:0]  act_y,
    output logic              layer_hit,
    output logic [DATA_W-1:0] px_color
);

    timing_t           work;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] bg;
    xy_t               pos;
    pix_out_t          pix;

    raster_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .work  (work),
        .ctrl  (ctrl),
        .bg    (bg)
    );

    raster_counters u_cnt (
        .clk (clk),
        .rst (rst),
        .en  (ctrl.en),
        .tot (work.tot_end),
        .pos (pos)
    );

    raster_decode u_dec (
        .pos      (pos),
        .ctrl     (ctrl),
        .sync_end (work.sync_end),
        .bp_end   (work.bp_end),
        .act_end  (work.act_end),
        .win_lo   (work.win_lo),
        .win_hi   (work.win_hi),
        .win_en   (work.win_en),
        .bg       (bg),
        .pix      (pix)
    );

    assign hsync     = pix.hs;
    assign vsync     = pix.vs;
    assign de        = pix.de;
    assign pclk_inv  = pix.pc;
    assign act_x     = pix.x;
    assign act_y     = pix.y;
    assign layer_hit = pix.hit;
    assign px_color  = pix.color;

    AST_DE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (layer_hit || px_color != '0) |-> ctrl.en); // R7

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    typedef struct {
        int sync_h, sync_v, bp_h, bp_v, act_h, act_v, tot_h, tot_v;
        int wlo_h, wlo_v, whi_h, whi_v;
        bit win_en;
    } mcfg_t;

    typedef struct {
        bit          hs, vs, de, pc;
        int          x, y;
        bit          hit;
        logic [31:0] color;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_we = 0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hsync, vsync, de, pclk_inv, layer_hit;
    logic [11:0] act_x, act_y;
    logic [31:0] px_color;

    raster_timing_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .hsync     (hsync),
        .vsync     (vsync),
        .de        (de),
        .pclk_inv  (pclk_inv),
        .act_x     (act_x),
        .act_y     (act_y),
        .layer_hit (layer_hit),
        .px_color  (px_color)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    mcfg_t m_cfg, m_shadow;
    bit [4:0] m_ctrl = '0;   // {pc, de, vs, hs, en}
    logic [31:0] m_bg = '0;
    int    mh = 0, mv = 0;
    exp_t  exp_q[$];
    int    cyc = 0;
    int    last_rise = -1;
    bit    prev_vs_act = 0;

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, expv, cyc);
        end
    endtask

    function automatic mcfg_t make_cfg(int hsw, int hbp, int aw, int hfp,
                                       int vsw, int vbp, int ah, int vfp,
                                       int ww, int wh, bit wen);
        mcfg_t c;
        c.sync_h = hsw - 1;             c.sync_v = vsw - 1;
        c.bp_h   = hsw + hbp - 1;       c.bp_v   = vsw + vbp - 1;
        c.act_h  = c.bp_h + aw;         c.act_v  = c.bp_v + ah;
        c.tot_h  = c.act_h + hfp;       c.tot_v  = c.act_v + vfp;
        c.wlo_h  = c.bp_h + 2;          c.whi_h  = c.bp_h + 1 + ww;
        c.wlo_v  = c.bp_v + 1;          c.whi_v  = c.bp_v + wh;
        c.win_en = wen;
        return c;
    endfunction

    function automatic logic [31:0] pack2(int lo, int hi);
        return {4'b0, hi[11:0], 4'b0, lo[11:0]};
    endfunction

    task automatic write_reg(int a, logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1; cfg_addr = a[3:0]; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic load_shadow(mcfg_t c);
        write_reg(0, pack2(c.sync_h, c.sync_v));
        write_reg(1, pack2(c.bp_h, c.bp_v));
        write_reg(2, pack2(c.act_h, c.act_v));
        write_reg(3, pack2(c.tot_h, c.tot_v));
        write_reg(6, pack2(c.wlo_h, c.whi_h));
        write_reg(7, pack2(c.wlo_v, c.whi_v));
        write_reg(8, {31'b0, c.win_en});
        m_shadow = c;
    endtask

    task automatic do_reload();
        write_reg(9, 32'h1);
        m_cfg = m_shadow;
    endtask

    task automatic set_ctrl(bit [4:0] v);
        write_reg(4, {27'b0, v});
        m_ctrl = v;
    endtask

    task automatic set_bg(logic [31:0] v);
        write_reg(5, v);
        m_bg = v;
    endtask

    // Driver side of the scoreboard: reference model pushes expected items
    always @(negedge clk) begin
        if (!rst && !done) begin
            exp_t e;
            bit en, de_in;
            en    = m_ctrl[0];
            de_in = en && mh > m_cfg.bp_h && mh <= m_cfg.act_h
                       && mv > m_cfg.bp_v && mv <= m_cfg.act_v;
            e.hs  = (en && mh <= m_cfg.sync_h) ? m_ctrl[1] : !m_ctrl[1];
            e.vs  = (en && mv <= m_cfg.sync_v) ? m_ctrl[2] : !m_ctrl[2];
            e.de  = de_in ? m_ctrl[3] : !m_ctrl[3];
            e.pc  = m_ctrl[4];
            e.x   = de_in ? mh - m_cfg.bp_h - 1 : 0;
            e.y   = de_in ? mv - m_cfg.bp_v - 1 : 0;
            e.hit = de_in && m_cfg.win_en && mh >= m_cfg.wlo_h && mh <= m_cfg.whi_h
                          && mv >= m_cfg.wlo_v && mv <= m_cfg.whi_v;
            e.color = (de_in && !e.hit) ? m_bg : 32'h0;
            exp_q.push_back(e);
            if (en) begin
                if (mh >= m_cfg.tot_h) begin
                    mh = 0;
                    mv = (mv >= m_cfg.tot_v) ? 0 : mv + 1;
                end else begin
                    mh = mh + 1;
                end
            end else begin
                mh = 0; mv = 0;
            end
        end
    end

    // Monitor side: pops expected items and compares with the outputs
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            exp_t e;
            bit vs_act;
            e = exp_q.pop_front();
            check(hsync == e.hs,      "R4", "hsync",     hsync, e.hs);
            check(vsync == e.vs,      "R4", "vsync",     vsync, e.vs);
            check(de == e.de,         "R5", "de",        de, e.de);
            check(pclk_inv == e.pc,   "R6", "pclk_inv",  pclk_inv, e.pc);
            check(act_x == e.x[11:0], "R8", "act_x",     act_x, e.x);
            check(act_y == e.y[11:0], "R8", "act_y",     act_y, e.y);
            check(layer_hit == e.hit, "R9", "layer_hit", layer_hit, e.hit);
            check(px_color == e.color, "R10", "px_color", px_color, e.color);
            // R3: frame length measured between vsync activations
            vs_act = m_ctrl[0] && (vsync == m_ctrl[2]);
            if (!m_ctrl[0]) last_rise = -1;
            if (vs_act && !prev_vs_act) begin
                if (last_rise >= 0)
                    check(cyc - last_rise == (m_cfg.tot_h + 1) * (m_cfg.tot_v + 1),
                          "R3", "frame length", cyc - last_rise,
                          (m_cfg.tot_h + 1) * (m_cfg.tot_v + 1));
                last_rise = cyc;
            end
            prev_vs_act = vs_act;
            cyc++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        mcfg_t ca, cb, cc;
        ca = make_cfg(2, 3, 8, 2, 1, 2, 4, 1, 3, 2, 1);   // frame 15*8
        cb = make_cfg(1, 1, 4, 1, 2, 1, 3, 2, 2, 2, 1);   // frame 7*8
        cc = make_cfg(3, 2, 5, 3, 1, 1, 2, 1, 2, 1, 0);   // frame 13*5, window off
        m_cfg = make_cfg(1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 0);
        m_cfg.sync_h = 0; m_cfg.sync_v = 0; m_cfg.bp_h = 0; m_cfg.bp_v = 0;
        m_cfg.act_h = 0; m_cfg.act_v = 0; m_cfg.tot_h = 0; m_cfg.tot_v = 0;
        m_cfg.wlo_h = 0; m_cfg.wlo_v = 0; m_cfg.whi_h = 0; m_cfg.whi_v = 0;
        m_shadow = m_cfg;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(hsync == 1'b1,     "R11", "reset hsync",     hsync, 1);
        check(vsync == 1'b1,     "R11", "reset vsync",     vsync, 1);
        check(de == 1'b1,        "R11", "reset de",        de, 1);
        check(pclk_inv == 1'b0,  "R11", "reset pclk_inv",  pclk_inv, 0);
        check(layer_hit == 1'b0, "R11", "reset layer_hit", layer_hit, 0);
        check(px_color == 32'h0, "R11", "reset px_color",  px_color, 0);
        @(posedge clk); #1;
        rst = 0;

        // Config A, all active-high, window on
        load_shadow(ca);
        set_bg(32'hAAAA_5555);
        do_reload();                          // R2
        set_ctrl(5'b11111);                   // R6 R7
        repeat (2 * 120 + 20) @(posedge clk);

        // R1: shadow write of B without reload, A must stay in force
        load_shadow(cb);
        repeat (130) @(posedge clk);
        set_ctrl(5'b00000);                   // R7 idle levels
        repeat (10) @(posedge clk);
        do_reload();
        set_ctrl(5'b00001);                   // B, all active-low
        repeat (2 * 56 + 10) @(posedge clk);

        // R2: request cleared itself, C shadow must not apply on re-enable
        load_shadow(cc);
        set_ctrl(5'b00000);
        repeat (5) @(posedge clk);
        set_ctrl(5'b00001);
        repeat (60) @(posedge clk);
        set_ctrl(5'b00000);
        do_reload();
        set_ctrl(5'b11011);                   // C, mixed polarities
        repeat (65 + 10) @(posedge clk);
        set_bg(32'h1234_5678);                // R10 direct colour write
        repeat (65 + 10) @(posedge clk);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule